// File: doc/BRIEF.md
# Indirect Filter Register Window

This block is a host-side register window into a bank of per-filter configuration words. The host sees only two directly addressable words: a command word and a data word. The command word names a filter, names a register inside that filter, says whether the transfer is a read or a write, and starts it by setting a start/busy bit. A small sequencer holds busy high for a fixed number of cycles. When that time is up it moves the data word into the selected entry, or moves the selected entry into the data word.

Software stages a write by loading the data word and then writing the command word with start set and the read flag clear. A read is launched with both the read flag and start set. Once busy reads back clear, the data word holds the entry. Busy can be read at all times, so software polls it before it issues the next transfer. The bank holds 8 filters with 4 words each (control, first layer-3 address, second layer-3 address, layer-4 ports). Every word is 32 bits, and all words are zero after reset.

Top module: `ifr_window`

## Requirements
- R1: After reset the command word and the data word both read as zero, and every bank entry reads back as zero.
- R2: The command word is laid out as follows: bit 0 is busy/start, bit 1 is read (1) or write (0), bits [11:8] are the register offset and bits [15:12] are the filter number. All other bits read as zero. The fields read back as last written.
- R3: A command-word write with bit 0 set while idle launches a transfer. Busy then reads as 1 for exactly 4 cycles after the write edge and reads as 0 after that.
- R4: A write transfer (bit 1 = 0) copies the data word into the selected entry when busy clears.
- R5: A read transfer (bit 1 = 1) loads the selected entry into the data word, and the value is readable once busy clears.
- R6: A command-word write while busy is set is ignored. The fields and the transfer in progress are not changed.
- R7: A data-word write while busy is set is ignored. The transfer in progress uses the value staged before launch.
- R8: A filter number of 8 or more, or an offset of 4 or more, still completes with normal busy timing. Such a write changes no entry, and such a read returns zero.
- R9: A command-word write with bit 0 clear updates the fields without launching a transfer.
- R10: All 32 filter/offset entries can be addressed independently, and each one keeps its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrSel | input | 1 | Write target: 0 command word, 1 data word |
| wrData | input | 32 | Host write data |
| rdSel | input | 1 | Read source: 0 command word, 1 data word |
| rdData | output | 32 | Selected direct word |

## Verification
The bench fills all 32 entries with distinct computed values and reads every one back. An indexing error that aliases a filter onto its neighbour therefore shows up as a value mismatch. Out-of-range numbers are chosen so that a truncated index would land on a live entry (filter 9 aliases to filter 1, offset 5 aliases to the next filter). A design that fails to drop those writes corrupts a checked entry. The bench issues command and data writes in the middle of a transfer. A design that does not lock those words would retarget the transfer or store the later data. The bench counts busy on every access, so an off-by-one countdown shows up as a cycle-count mismatch.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } regSel_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic ctlLoad;   // capture command-word fields
    logic dataLoad;  // capture data word from the host
    logic doWrite;   // commit data word into the selected entry
    logic doRead;    // fetch the selected entry into the data word
  } ifrStrobe_t;

endpackage

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       startBit,
  input  logic       typeBit,
  output logic       busy,
  output ifrStrobe_t strb
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam int LEN_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic             launch;

  assign launch = !busy && wrEn && (wrSel == SEL_CTRL) && startBit;

  always_comb begin
    strb = '0;
    if (!busy && wrEn) begin
      if (wrSel == SEL_CTRL) strb.ctlLoad  = 1'b1;
      else                   strb.dataLoad = 1'b1;
    end
    if (busy && cnt == '0) begin
      strb.doRead  = isRead;
      strb.doWrite = !isRead;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      isRead <= 1'b0;
    end else if (!busy) begin
      if (launch) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(LATENCY - 1);
        isRead <= typeBit;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // Busy-length monitor used by the assertions below.
  logic [LEN_W-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy);                                             // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == LEN_W'(LATENCY)));               // R3
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doWrite, strb.doRead}));                      // R4
  AST_ACTION_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite || strb.doRead) |=> !busy);                    // R3

endmodule

// File: rtl/ifr_regs.sv
module ifr_regs
  import ifr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_FILT = 8,
  parameter int REGS_PER = 4,
  parameter int FNUM_W   = 4,
  parameter int ROFF_W   = 4,
  parameter int IDX_LSB  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int ENTRIES  = NUM_FILT * REGS_PER;
  localparam int AIDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int ROFF_LSB = IDX_LSB;
  localparam int FNUM_LSB = IDX_LSB + ROFF_W;

  logic [FNUM_W-1:0] filtNum;
  logic [ROFF_W-1:0] regOff;
  logic              xferRead;
  logic [DATA_W-1:0] dataWord;
  logic [DATA_W-1:0] entry [ENTRIES];
  logic              inRange;
  logic [AIDX_W-1:0] entryIdx;

  assign inRange  = (int'(filtNum) < NUM_FILT) && (int'(regOff) < REGS_PER);
  assign entryIdx = AIDX_W'(int'(filtNum) * REGS_PER + int'(regOff));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtNum  <= '0;
      regOff   <= '0;
      xferRead <= 1'b0;
    end else if (strb.ctlLoad) begin
      filtNum  <= wrData[FNUM_LSB +: FNUM_W];
      regOff   <= wrData[ROFF_LSB +: ROFF_W];
      xferRead <= wrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataWord <= '0;
    else if (strb.dataLoad) dataWord <= wrData;
    else if (strb.doRead)   dataWord <= inRange ? entry[entryIdx] : '0;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entry[g] <= '0;
      else if (strb.doWrite && inRange && entryIdx == AIDX_W'(g))
        entry[g] <= dataWord;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel == SEL_DATA) begin
      rdData = dataWord;
    end else begin
      rdData[0]                   = busy;
      rdData[1]                   = xferRead;
      rdData[ROFF_LSB +: ROFF_W]  = regOff;
      rdData[FNUM_LSB +: FNUM_W]  = filtNum;
    end
  end

  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({filtNum, regOff, xferRead}));             // R6
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.doRead) |=> $stable(dataWord));              // R7
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRead && !inRange) |=> (dataWord == '0));            // R8
  AST_ACTION_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite || strb.doRead) |-> busy);                    // R3

endmodule

// File: rtl/ifr_window.sv
module ifr_window
  import ifr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_FILT = 8,
  parameter int REGS_PER = 4,
  parameter int FNUM_W   = 4,
  parameter int ROFF_W   = 4,
  parameter int IDX_LSB  = 8,
  parameter int LATENCY  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData
);

  ifrStrobe_t strb;
  logic       busy;

  ifr_seq #(.LATENCY(LATENCY)) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .startBit (wrData[0]),
    .typeBit  (wrData[1]),
    .busy     (busy),
    .strb     (strb)
  );

  ifr_regs #(
    .DATA_W   (DATA_W),
    .NUM_FILT (NUM_FILT),
    .REGS_PER (REGS_PER),
    .FNUM_W   (FNUM_W),
    .ROFF_W   (ROFF_W),
    .IDX_LSB  (IDX_LSB)
  ) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .busy   (busy),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

endmodule

// File: tb/sim_ifr_window.sv
`timescale 1ns/1ps
module sim_ifr_window;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic        wrSel;
  logic [31:0] wrData;
  logic        rdSel;
  logic [31:0] rdData;

  always #2 clk = ~clk;

  ifr_window u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData)
  );

  int nChk = 0;
  int nBad = 0;
  logic [31:0] model [8][4];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlWord(input int f, input int r, input bit rd, input bit go);
    return (32'(f) << 12) | (32'(r) << 8) | (32'(rd) << 1) | 32'(go);
  endfunction

  function automatic logic [31:0] pattern(input int f, input int r);
    return 32'hA500_0000 ^ (32'(f) << 16) ^ (32'(r) << 4) ^ 32'(f * 37 + r * 11 + 1);
  endfunction

  task automatic hw(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [31:0] v);
    rdSel = sel; #0.5;
    v = rdData;
    rdSel = 1'b0; #0.5;
  endtask

  task automatic waitDone(output int cyc);
    logic [31:0] v;
    cyc = 0;
    peek(1'b0, v);
    while (v[0] && cyc < 50) begin
      cyc++;
      @(negedge clk);
      peek(1'b0, v);
    end
  endtask

  task automatic wrEntry(input int f, input int r, input logic [31:0] val, output int cyc);
    hw(1'b1, val);
    hw(1'b0, ctlWord(f, r, 1'b0, 1'b1));
    waitDone(cyc);
  endtask

  task automatic rdEntry(input int f, input int r, output logic [31:0] val, output int cyc);
    hw(1'b0, ctlWord(f, r, 1'b1, 1'b1));
    waitDone(cyc);
    peek(1'b1, val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] a;
    int cyc;
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0; rdSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 4; r++) model[f][r] = '0;

    // R1: reset state
    peek(1'b0, v); check("R1 ctrl", v, 32'h0);
    peek(1'b1, v); check("R1 data", v, 32'h0);
    rdEntry(3, 2, v, cyc);
    check("R1 entry", v, 32'h0);
    check("R3 busy cycles", 32'(cyc), 32'd4);

    // R2 / R9: field readback, no launch without start
    hw(1'b0, 32'hFFFF_53FE);
    peek(1'b0, v); check("R2 layout", v, 32'h0000_5302);
    repeat (2) @(negedge clk);
    peek(1'b0, v); check("R9 no launch", v, 32'h0000_5302);
    peek(1'b1, v); check("R9 data kept", v, 32'h0);

    // R4 / R3: write sweep
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 4; r++) begin
        wrEntry(f, r, pattern(f, r), cyc);
        model[f][r] = pattern(f, r);
        check("R3 write busy", 32'(cyc), 32'd4);
      end
    // R5 / R10: read sweep
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 4; r++) begin
        rdEntry(f, r, v, cyc);
        check("R5 R10 readback", v, model[f][r]);
      end

    // R6: command write during busy is ignored
    hw(1'b1, 32'hDEAD_BEEF);
    hw(1'b0, ctlWord(1, 1, 1'b0, 1'b1));
    hw(1'b0, ctlWord(2, 2, 1'b1, 1'b1));
    peek(1'b0, v); check("R6 fields", v & 32'hFFFF_FFFE, ctlWord(1, 1, 1'b0, 1'b0));
    waitDone(cyc);
    model[1][1] = 32'hDEAD_BEEF;
    rdEntry(1, 1, v, cyc); check("R6 target", v, model[1][1]);
    rdEntry(2, 2, v, cyc); check("R6 other", v, model[2][2]);

    // R7: data write during busy is ignored
    a = 32'h1357_9BDF;
    hw(1'b1, a);
    hw(1'b0, ctlWord(4, 0, 1'b0, 1'b1));
    hw(1'b1, 32'h2468_ACE0);
    peek(1'b1, v); check("R7 data held", v, a);
    waitDone(cyc);
    model[4][0] = a;
    rdEntry(4, 0, v, cyc); check("R7 committed", v, a);

    // R8: out-of-range accesses
    wrEntry(9, 0, 32'h1234_5678, cyc);
    check("R8 busy oor", 32'(cyc), 32'd4);
    wrEntry(0, 5, 32'h8765_4321, cyc);
    rdEntry(1, 0, v, cyc); check("R8 alias f", v, model[1][0]);
    rdEntry(1, 1, v, cyc); check("R8 alias r", v, model[1][1]);
    hw(1'b1, 32'hFFFF_FFFF);
    rdEntry(12, 1, v, cyc); check("R8 read zero f", v, 32'h0);
    check("R8 read busy", 32'(cyc), 32'd4);
    hw(1'b1, 32'hFFFF_FFFF);
    rdEntry(2, 7, v, cyc); check("R8 read zero r", v, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule